// File: doc/BRIEF.md
# Dual-Protocol Auto-Refresh Scheduler

This block sits in a memory controller and issues AUTO REFRESH commands to a memory with sixteen banks. Per-bank refresh requests arrive as single-cycle pulses and stay pending until served. Each cycle the block decides whether a refresh may go out on the shared command bus. If it may, it drives the strobes, the bank address and the address lines directly; the outputs are combinational from internal state and the current inputs.

A mode input picks one of two encodings. In single-bank mode one bank is refreshed per command and is named on the bank address. In multibank mode the address lines carry a bitmask with one bit per bank. Up to four pending banks are merged into one command, taken from the lowest index upward.

Other agents on the same bus (reads, writes) report their bank commands on a side input. The block never drives a refresh in such a cycle. It counts those commands against the per-bank row-cycle timer, the rolling activation window and the spacing rule around multibank refresh.

Top module: `rfsh_sched`

## Requirements
- R1: When no refresh is issued, the bus is idle: `cs_n`, `we_n` and `ref_n` are 1, and `ba` and `addr` are 0. This includes the cycles while `rst` is high.
- R2: A refresh lasts one cycle and is encoded as `cs_n`=0, `ref_n`=0, `we_n`=1.
- R3: With `mode_multi`=0, each refresh names exactly one bank on `ba` (bank index 0..15), and `addr` is all zero.
- R4: With `mode_multi`=1, `addr[n]`=1 selects bank n, `ba` is zero, and between one and four bits of `addr` are set.
- R5: Among eligible pending banks, the lowest indices are served first. Banks left over stay pending for a later command.
- R6: A request stays pending until it is served, and it is served exactly once. Without a new request, a served bank gets no further refresh.
- R7: A bank is not refreshed until T_RC cycles after the last command to it, whether a refresh or a host command. A command in cycle c allows a refresh from cycle c+T_RC.
- R8: Any T_SAW consecutive cycles hold at most four bank activations. Each refreshed bank and each host command counts as one activation.
- R9: After a multibank refresh of three or four banks in cycle c, no refresh is issued before cycle c+T_MMD.
- R10: With `mode_multi`=1, a refresh is issued no earlier than MB_GAP cycles after the previous bank command of any kind.
- R11: No refresh is issued in a cycle in which `host_cmd_v` is 1.
- R12: The scheduler is work-conserving: in every cycle where the rules above allow it, it issues as many eligible banks as they permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_multi | input | 1 | 0: single-bank refresh by bank address; 1: multibank refresh by address mask |
| ref_req | input | 16 | Per-bank refresh request pulses |
| host_cmd_v | input | 1 | Another agent drives a bank command this cycle |
| host_cmd_ba | input | 4 | Bank of that command |
| cs_n | output | 1 | Chip select, active low |
| we_n | output | 1 | Write enable, active low |
| ref_n | output | 1 | Refresh strobe, active low |
| ba | output | 4 | Bank address (single-bank mode) |
| addr | output | 16 | Bank mask (multibank mode) |

## Verification
A cycle-stamp reference model runs alongside the design and predicts every output in every cycle. It is driven by sparse random requests and by host commands that obey the spacing rules; this separates work conservation from any early or late grant. In multibank mode every mask with one to four set bits is applied to an otherwise empty window, which must come back unchanged in the following cycle. Directed sequences then isolate each spacing rule by making it the only limit. A repeated single request shows the row-cycle limit. Sixteen simultaneous requests show the four-per-window limit and the lowest-first order. Three banks followed by a fourth show the wide-refresh hold, and a host command next to a pending bank shows the multibank gap.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int BANKS    = 16;
    localparam int BA_W     = $clog2(BANKS);
    localparam int MB_MAX   = 4;
    localparam int CNT_W    = $clog2(MB_MAX + 1);
    localparam int MMD_FROM = 3;

    typedef logic [BANKS-1:0] bmask_t;
    typedef logic [CNT_W-1:0] bcnt_t;
    typedef logic [BA_W:0]    pcnt_t;

    typedef enum logic {MODE_ONE = 1'b0, MODE_MULTI = 1'b1} rmode_e;

    typedef struct packed {
        logic            cs_n;
        logic            we_n;
        logic            ref_n;
        logic [BA_W-1:0] ba;
        bmask_t          addr;
    } busw_t;

    localparam busw_t BUS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, ref_n: 1'b1, ba: '0, addr: '0};

    function automatic pcnt_t ones(input bmask_t m);
        pcnt_t c = '0;
        for (int i = 0; i < BANKS; i++) c = c + pcnt_t'(m[i]);
        return c;
    endfunction

    function automatic logic [BA_W-1:0] low_idx(input bmask_t m);
        logic [BA_W-1:0] r = '0;
        for (int i = BANKS - 1; i >= 0; i--) if (m[i]) r = i[BA_W-1:0];
        return r;
    endfunction

    function automatic bmask_t take_low(input bmask_t elig, input bcnt_t limit);
        bmask_t r   = '0;
        bcnt_t  got = '0;
        for (int i = 0; i < BANKS; i++) begin
            if (elig[i] && got < limit) begin
                r[i] = 1'b1;
                got  = got + bcnt_t'(1);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rfsh_bank_timers.sv
module rfsh_bank_timers
    import rfsh_pkg::*;
#(
    parameter int T_RC = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  bmask_t touch,
    input  bmask_t ref_fire,
    output bmask_t busy
);
    localparam int TW = $clog2(T_RC + 1);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [TW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)                cnt <= '0;
            else if (touch[b])      cnt <= TW'(T_RC - 1);
            else if (cnt != '0)     cnt <= cnt - TW'(1);
        end
        assign busy[b] = (cnt != '0);
    end

    AST_RC_WAIT: assert property (@(posedge clk) disable iff (rst)
        (ref_fire & busy) == '0) else $error("refresh to a bank inside its row cycle"); // R7

endmodule

// File: rtl/rfsh_saw_window.sv
module rfsh_saw_window
    import rfsh_pkg::*;
#(
    parameter int T_SAW = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  bcnt_t n_new,
    output bcnt_t n_free
);
    localparam int SW = $clog2(T_SAW + 1);

    logic [SW-1:0]     slot [MB_MAX];
    logic [MB_MAX-1:0] occ;
    logic [MB_MAX-1:0] load;
    bcnt_t             given;

    always_comb begin
        load  = '0;
        given = '0;
        for (int s = 0; s < MB_MAX; s++) begin
            if (!occ[s] && given < n_new) begin
                load[s] = 1'b1;
                given   = given + bcnt_t'(1);
            end
        end
    end

    for (genvar s = 0; s < MB_MAX; s++) begin : g_slot
        assign occ[s] = (slot[s] != '0);
        always_ff @(posedge clk) begin
            if (rst)            slot[s] <= '0;
            else if (load[s])   slot[s] <= SW'(T_SAW - 1);
            else if (occ[s])    slot[s] <= slot[s] - SW'(1);
        end
    end

    always_comb begin
        n_free = bcnt_t'(MB_MAX);
        for (int s = 0; s < MB_MAX; s++) if (occ[s]) n_free = n_free - bcnt_t'(1);
    end

    AST_SAW_CAP: assert property (@(posedge clk) disable iff (rst)
        n_new <= n_free) else $error("activation window overfilled"); // R8

endmodule

// File: rtl/rfsh_pick.sv
module rfsh_pick
    import rfsh_pkg::*;
(
    input  rmode_e mode,
    input  bmask_t pend,
    input  bmask_t busy,
    input  bcnt_t  n_free,
    input  logic   allow,
    output bmask_t fire,
    output bcnt_t  n_fire
);
    bcnt_t limit;
    pcnt_t cnt;

    always_comb begin
        if (!allow)                 limit = '0;
        else if (mode == MODE_MULTI) limit = n_free;
        else                        limit = (n_free != '0) ? bcnt_t'(1) : '0;
    end

    assign fire   = take_low(pend & ~busy, limit);
    assign cnt    = ones(fire);
    assign n_fire = cnt[CNT_W-1:0];

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int T_RC   = 8,
    parameter int T_MMD  = 6,
    parameter int T_SAW  = 12,
    parameter int MB_GAP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_multi,
    input  logic [BANKS-1:0]  ref_req,
    input  logic              host_cmd_v,
    input  logic [BA_W-1:0]   host_cmd_ba,
    output logic              cs_n,
    output logic              we_n,
    output logic              ref_n,
    output logic [BA_W-1:0]   ba,
    output logic [BANKS-1:0]  addr
);
    localparam int MW = $clog2(T_MMD + 1);
    localparam int GW = $clog2(MB_GAP + 1);

    rmode_e        mode;
    bmask_t        pend, busy, fire, host_mask, touch;
    bcnt_t         n_free, n_fire, n_new;
    logic [MW-1:0] mmd_cnt;
    logic [GW-1:0] gap_cnt;
    logic          allow;
    busw_t         bus;

    assign mode      = rmode_e'(mode_multi);
    assign host_mask = host_cmd_v ? (bmask_t'(1) << host_cmd_ba) : '0;
    assign allow     = !host_cmd_v && (mmd_cnt == '0) && (mode == MODE_ONE || gap_cnt == '0);
    assign touch     = fire | host_mask;
    assign n_new     = n_fire + bcnt_t'(host_cmd_v);

    rfsh_bank_timers #(.T_RC(T_RC)) u_timers (
        .clk(clk), .rst(rst), .touch(touch), .ref_fire(fire), .busy(busy)
    );

    rfsh_saw_window #(.T_SAW(T_SAW)) u_window (
        .clk(clk), .rst(rst), .n_new(n_new), .n_free(n_free)
    );

    rfsh_pick u_pick (
        .mode(mode), .pend(pend), .busy(busy), .n_free(n_free),
        .allow(allow), .fire(fire), .n_fire(n_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~fire) | ref_req;
    end

    always_ff @(posedge clk) begin
        if (rst)                                                  mmd_cnt <= '0;
        else if (mode == MODE_MULTI && n_fire >= bcnt_t'(MMD_FROM)) mmd_cnt <= MW'(T_MMD - 1);
        else if (mmd_cnt != '0)                                   mmd_cnt <= mmd_cnt - MW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)                              gap_cnt <= '0;
        else if (host_cmd_v || fire != '0)    gap_cnt <= GW'(MB_GAP - 1);
        else if (gap_cnt != '0)               gap_cnt <= gap_cnt - GW'(1);
    end

    always_comb begin
        bus = BUS_IDLE;
        if (fire != '0) begin
            bus.cs_n  = 1'b0;
            bus.ref_n = 1'b0;
            if (mode == MODE_MULTI) bus.addr = fire;
            else                    bus.ba   = low_idx(fire);
        end
    end

    assign {cs_n, we_n, ref_n, ba, addr} = bus;

    AST_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        host_cmd_v |-> ref_n) else $error("refresh collides with host command"); // R11
    AST_STROBES: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (!ref_n && we_n)) else $error("bad strobe encoding"); // R2
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        (!ref_n && !mode_multi) |-> (addr == '0)) else $error("address used in single mode"); // R3
    AST_MASK_SIZE: assert property (@(posedge clk) disable iff (rst)
        (!ref_n && mode_multi) |-> ($countones(addr) >= 1 && $countones(addr) <= MB_MAX && ba == '0))
        else $error("bank mask out of range"); // R4
    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ref_n && mode_multi && $countones(addr) >= MMD_FROM) |=> ref_n)
        else $error("refresh right after wide refresh"); // R9
    AST_MB_GAP: assert property (@(posedge clk) disable iff (rst)
        (!ref_n && mode_multi) |-> (gap_cnt == '0)) else $error("multibank gap broken"); // R10

endmodule

// File: tb/test_rfsh_sched.sv
module test_rfsh_sched;
    localparam int TRC = 8, TMMD = 6, TSAW = 12, GAP = 2;

    logic        clk = 1'b0, rst = 1'b1, mode = 1'b0;
    logic [15:0] req = '0;
    logic        hv = 1'b0;
    logic [3:0]  hb = '0;
    logic        cs_n, we_n, ref_n;
    logic [3:0]  ba;
    logic [15:0] addr;

    always #2 clk = ~clk;

    rfsh_sched #(.T_RC(TRC), .T_MMD(TMMD), .T_SAW(TSAW), .MB_GAP(GAP)) i_rfsh_sched (
        .clk(clk), .rst(rst), .mode_multi(mode), .ref_req(req),
        .host_cmd_v(hv), .host_cmd_ba(hb),
        .cs_n(cs_n), .we_n(we_n), .ref_n(ref_n), .ba(ba), .addr(addr)
    );

    int total = 0, bad = 0, n = 0;
    int lastb [16];
    int acts  [16];
    int aw = 0, last_any, last_big, last_mb;
    logic [15:0] mpend;
    int g_cnt = 0, g_cyc = -1;
    logic [15:0] g_addr;
    logic [3:0]  g_ba;
    logic [2:0]  g_str;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, n);
        end
    endtask

    function automatic int in_window();
        int c = 0;
        for (int i = 0; i < 16; i++) if (n - acts[i] < TSAW) c++;
        return c;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin lastb[i] = -1000; acts[i] = -1000; end
        last_any = -1000; last_big = -1000; last_mb = -1000; mpend = '0; n = 0;
    endtask

    task automatic push_act();
        acts[aw] = n;
        aw = (aw + 1) % 16;
    endtask

    task automatic step(input logic [15:0] r, input bit h, input logic [3:0] b);
        int win, lim, taken, idx;
        bit ok;
        logic [15:0] ef;
        logic [22:0] exp, act;
        string tag;
        @(negedge clk);
        req = r; hv = h; hb = b;
        #1;
        win = in_window();
        ok = !h && (n - last_big >= TMMD) && (!mode || n - last_any >= GAP);
        lim = !ok ? 0 : (mode ? 4 - win : (win < 4 ? 1 : 0));
        ef = '0; taken = 0; idx = 0;
        for (int i = 0; i < 16; i++)
            if (mpend[i] && n - lastb[i] >= TRC && taken < lim) begin
                ef[i] = 1'b1;
                if (taken == 0) idx = i;
                taken++;
            end
        if (ef == '0)     begin exp = {3'b111, 4'h0, 16'h0};      tag = "R1 R12 idle"; end
        else if (mode)    begin exp = {3'b010, 4'h0, ef};         tag = "R2 R4 R12 multibank"; end
        else              begin exp = {3'b010, 4'(idx), 16'h0};   tag = "R2 R3 R12 single"; end
        act = {cs_n, we_n, ref_n, ba, addr};
        chk(act == exp, tag, 32'(act), 32'(exp));
        if (!ref_n) begin
            g_cnt++; g_cyc = n; g_addr = addr; g_ba = ba; g_str = {cs_n, we_n, ref_n};
        end
        for (int i = 0; i < 16; i++) if (ef[i]) begin lastb[i] = n; push_act(); end
        if (ef != '0) last_any = n;
        if (mode && taken >= 3) last_big = n;
        if (mode && ef != '0) last_mb = n;
        if (h) begin lastb[b] = n; push_act(); last_any = n; end
        mpend = (mpend & ~ef) | r;
        n++;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step('0, 1'b0, '0);
    endtask

    task automatic wait_grant(output int t);
        int c0 = g_cnt;
        for (int i = 0; i < 60 && g_cnt == c0; i++) step('0, 1'b0, '0);
        t = g_cyc;
    endtask

    task automatic rand_phase(input int cycles);
        for (int k = 0; k < cycles; k++) begin
            logic [15:0] r;
            bit h;
            logic [3:0] b;
            r = '0;
            if ($urandom % 6 == 0)  r = 16'h1 << ($urandom % 16);
            if ($urandom % 25 == 0) r = r | 16'($urandom);
            b = 4'($urandom % 16);
            h = ($urandom % 4 == 0) && (n - lastb[b] >= TRC) && (in_window() < 4)
                && !(mode && n - last_mb < GAP);
            step(r, h, b);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t1, t2, t0, t4, c, th;
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        chk({cs_n, we_n, ref_n, ba, addr} == {3'b111, 20'h0}, "R1 reset idle",
            32'({cs_n, we_n, ref_n, ba, addr}), 32'({3'b111, 20'h0}));
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // single-bank mode: row cycle and encoding
        step(16'h0008, 1'b0, '0);
        wait_grant(t1);
        chk(g_ba == 4'd3, "R3 bank index", 32'(g_ba), 3);
        chk(g_addr == '0, "R3 address zero", 32'(g_addr), 0);
        chk(g_str == 3'b010, "R2 strobes", 32'(g_str), 32'b010);
        step(16'h0008, 1'b0, '0);
        wait_grant(t2);
        chk(t2 - t1 == TRC, "R7 row cycle spacing", 32'(t2 - t1), TRC);
        c = g_cnt;
        idle(30);
        chk(g_cnt == c, "R6 served once", 32'(g_cnt), 32'(c));

        // single-bank order and window
        step(16'hFFFF, 1'b0, '0);
        t0 = 0; t4 = 0;
        for (int k = 0; k < 16; k++) begin
            wait_grant(t1);
            chk(g_ba == 4'(k), "R5 lowest first single", 32'(g_ba), 32'(k));
            if (k == 0) t0 = t1;
            if (k == 4) t4 = t1;
        end
        chk(t4 - t0 == TSAW, "R8 window single", 32'(t4 - t0), TSAW);
        idle(20);
        rand_phase(3000);
        idle(40);

        mode = 1'b1;
        idle(20);

        // multibank gap and host clash
        step(16'h0001, 1'b0, '0);
        c = g_cnt;
        th = n;
        step('0, 1'b1, 4'd9);
        chk(g_cnt == c, "R11 no refresh with host command", 32'(g_cnt), 32'(c));
        wait_grant(t1);
        chk(t1 - th == GAP, "R10 multibank gap", 32'(t1 - th), GAP);
        chk(g_addr == 16'h0001, "R4 mask bank0", 32'(g_addr), 1);
        idle(20);

        // merge order and window
        step(16'hFFFF, 1'b0, '0);
        wait_grant(t1);
        chk(g_addr == 16'h000F, "R5 first four", 32'(g_addr), 32'h000F);
        wait_grant(t2);
        chk(g_addr == 16'h00F0, "R5 leftovers next", 32'(g_addr), 32'h00F0);
        chk(t2 - t1 == TSAW, "R8 window multibank", 32'(t2 - t1), TSAW);
        wait_grant(t1);
        chk(g_addr == 16'h0F00, "R5 third group", 32'(g_addr), 32'h0F00);
        wait_grant(t1);
        chk(g_addr == 16'hF000, "R5 last group", 32'(g_addr), 32'hF000);
        idle(20);

        // wide refresh hold
        step(16'h0007, 1'b0, '0);
        step(16'h0008, 1'b0, '0);
        t1 = g_cyc;
        chk(g_addr == 16'h0007, "R4 three-bank mask", 32'(g_addr), 7);
        wait_grant(t2);
        chk(t2 - t1 == TMMD, "R9 wide refresh hold", 32'(t2 - t1), TMMD);
        chk(g_addr == 16'h0008, "R4 follow-up mask", 32'(g_addr), 8);
        idle(20);

        // every mask of one to four banks into an empty window
        for (int m = 1; m < 65536; m++) begin
            if ($countones(m) <= 4) begin
                step(16'(m), 1'b0, '0);
                step('0, 1'b0, '0);
                chk(g_cyc == n - 1 && g_addr == 16'(m), "R4 mask passthrough", 32'(g_addr), 32'(m));
                idle(TSAW);
            end
        end

        rand_phase(3000);
        idle(60);
        c = g_cnt;
        idle(30);
        chk(g_cnt == c, "R6 nothing left pending", 32'(g_cnt), 32'(c));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule